// File: doc/BRIEF.md
# Stereo PDM Host Receiver

This block is the host-side front end for one or two pulse-density-modulated microphones that share a single data wire. It divides the system clock to make the microphone bit clock. It then takes the two 1-bit channels from that wire: the left microphone is latched at the falling edge of the bit clock, and the right one at the rising edge. Both samples are taken in the system-clock domain, in the last system cycle before the bit-clock edge concerned. This leaves almost a full half period for the microphone driver to settle.

The captured bits come out as a left/right pair once per bit-clock period. A per-channel strobe marks a valid pair one system cycle after the rising edge. A mode input selects stereo or a single microphone, and masks the strobe of the channel that has no driver. Lowering the enable holds the bit clock low, which lets the microphones go to sleep. After every enable, the strobes stay low while the microphones start up, for a parameterised number of bit-clock periods. Decimation, PCM conversion and offset removal happen downstream.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While `rst_ni` is low or `en_i` is low, `pdm_clk_o` is held low and static, and both strobes stay low.
- R2: While enabled, every high phase and every low phase of `pdm_clk_o` lasts exactly `half_div_i` system cycles, which gives a 50% duty cycle. A setting of 0 is treated as 1.
- R3: The left bit is the value of `pdm_dat_i` sampled at the system edge on which `pdm_clk_o` falls, which is the end of the last system cycle before that fall.
- R4: The right bit is the value of `pdm_dat_i` sampled at the system edge on which `pdm_clk_o` rises.
- R5: The pair is presented on `left_o`/`right_o` during the single system cycle that follows the rising edge of `pdm_clk_o`. The strobes are one cycle wide, at most one per bit-clock period. The left bit of a pair is the bit captured at the fall that comes just before the rise.
- R6: After enable, no strobe is issued for the first `WAKE_CYCLES` rising edges of `pdm_clk_o`. The first strobe follows rising edge number `WAKE_CYCLES`+1.
- R7: `mode_i` encoding: 0 and 3 mean stereo (both strobes), 1 means left only (`right_vld_o` held low), and 2 means right only (`left_vld_o` held low).
- R8: Dropping `en_i` clears the start-up count, so every re-enable waits the full start-up interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Runs the bit clock; low gates it off |
| half_div_i | input | DIV_W | System cycles per half bit-clock period |
| mode_i | input | 2 | Channel mode: 0/3 stereo, 1 left only, 2 right only |
| pdm_dat_i | input | 1 | Shared microphone data wire |
| pdm_clk_o | output | 1 | Bit clock to the microphones |
| left_o | output | 1 | Left bit of the current pair |
| right_o | output | 1 | Right bit of the current pair |
| left_vld_o | output | 1 | Left bit valid strobe |
| right_vld_o | output | 1 | Right bit valid strobe |

## Verification
The bench builds the block with `DIV_W` = 4 and `WAKE_CYCLES` = 8. This makes the start-up hold-off short enough to pass through in every run.

The bench sweeps every half-period setting from 0 to 6 against all four mode codes. Each run includes a disable and re-enable, so R8 is exercised 28 times.

Two behavioural microphone models drive the wire after their launching edges, and each stays silent in the mode where it is absent. Expected pairs, strobe cycles and phase lengths are computed from the rising-edge index and the setting in use.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  typedef enum logic [1:0] {
    MODE_STEREO = 2'd0,
    MODE_LEFT   = 2'd1,
    MODE_RIGHT  = 2'd2,
    MODE_BOTH   = 2'd3
  } pdm_mode_e;
endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             pdm_clk_o,
  output logic             rise_pre_o,
  output logic             fall_pre_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;
  logic             pdm_clk_q;
  logic             last;

  assign limit = (half_div_i == '0) ? '0 : half_div_i - 1'b1;
  assign last  = (cnt_q >= limit);

  // edge happens on the system edge that ends the last cycle of a phase
  assign rise_pre_o = en_i && last && !pdm_clk_q;
  assign fall_pre_o = en_i && last &&  pdm_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pdm_clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      pdm_clk_q <= 1'b0;
    end else if (last) begin
      cnt_q     <= '0;
      pdm_clk_q <= !pdm_clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pdm_clk_o = pdm_clk_q;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pdm_clk_q); // R1
  AST_RISE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_pre_o |=> pdm_clk_q); // R4
  AST_FALL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_pre_o |=> !pdm_clk_q); // R3
endmodule

// File: rtl/pdm_wake_timer.sv
module pdm_wake_timer #(
  parameter int WAKE_CYCLES = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_pre_i,
  output logic ready_o
);
  localparam int CW = $clog2(WAKE_CYCLES + 2);
  localparam logic [CW-1:0] WAKE_END = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == WAKE_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (rise_pre_i && !ready_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_WAKE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R8
  AST_WAKE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WAKE_END); // R6
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pdm_dat_i,
  input  logic       rise_pre_i,
  input  logic       fall_pre_i,
  input  logic       ready_i,
  output logic       left_o,
  output logic       right_o,
  output logic       left_vld_o,
  output logic       right_vld_o
);
  pdm_mode_e mode;
  logic      use_left, use_right;
  logic      left_hold_q;

  assign mode      = pdm_mode_e'(mode_i);
  assign use_left  = (mode != MODE_RIGHT);
  assign use_right = (mode != MODE_LEFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= 1'b0;
      left_o      <= 1'b0;
      right_o     <= 1'b0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      if (fall_pre_i) left_hold_q <= pdm_dat_i;
      if (rise_pre_i) begin
        right_o <= pdm_dat_i;
        left_o  <= left_hold_q;
      end
      left_vld_o  <= rise_pre_i && ready_i && use_left;
      right_vld_o <= rise_pre_i && ready_i && use_right;
    end
  end

  AST_RIGHT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_vld_o |-> ($past(mode_i) != MODE_LEFT)); // R7
  AST_LEFT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |-> ($past(mode_i) != MODE_RIGHT)); // R7
  AST_STROBE_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_vld_o || right_vld_o) |-> $past(rise_pre_i && ready_i)); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_vld_o || right_vld_o) |=> !(left_vld_o || right_vld_o)); // R5
endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx #(
  parameter int DIV_W       = 8,
  parameter int WAKE_CYCLES = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [1:0]       mode_i,
  input  logic             pdm_dat_i,
  output logic             pdm_clk_o,
  output logic             left_o,
  output logic             right_o,
  output logic             left_vld_o,
  output logic             right_vld_o
);
  logic rise_pre, fall_pre, ready;

  pdm_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .half_div_i (half_div_i),
    .pdm_clk_o  (pdm_clk_o),
    .rise_pre_o (rise_pre),
    .fall_pre_o (fall_pre)
  );

  pdm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .rise_pre_i (rise_pre),
    .ready_o    (ready)
  );

  pdm_capture u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .pdm_dat_i   (pdm_dat_i),
    .rise_pre_i  (rise_pre),
    .fall_pre_i  (fall_pre),
    .ready_i     (ready),
    .left_o      (left_o),
    .right_o     (right_o),
    .left_vld_o  (left_vld_o),
    .right_vld_o (right_vld_o)
  );

  AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(left_vld_o || right_vld_o)); // R1
endmodule

// File: tb/pdm_stereo_rx_bench.sv
`timescale 1ns/1ps
module pdm_stereo_rx_bench;
  localparam int DIV_W = 4;
  localparam int WAKE  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [DIV_W-1:0] half_div_i = '0;
  logic [1:0]       mode_i = 2'd0;
  logic             pdm_dat_i = 1'b0;
  logic             pdm_clk_o, left_o, right_o, left_vld_o, right_vld_o;

  int n_chk = 0;
  int n_err = 0;
  int rise_cnt = 0;
  int run_len = 0;
  int exp_half = 1;
  bit meas_on = 1'b0;
  bit seen_edge = 1'b0;
  logic prev_clk = 1'b0;

  pdm_stereo_rx #(.DIV_W(DIV_W), .WAKE_CYCLES(WAKE)) u_pdm_stereo_rx (
    .clk_i, .rst_ni, .en_i, .half_div_i, .mode_i, .pdm_dat_i,
    .pdm_clk_o, .left_o, .right_o, .left_vld_o, .right_vld_o
  );

  always #5 clk_i = !clk_i;

  function automatic logic lbit(int n);
    return ((n * 37) % 5) < 2;
  endfunction
  function automatic logic rbit(int n);
    return ((n * 11 + 4) % 3) == 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b (half=%0d mode=%0d rise=%0d)",
               req, act, exp, half_div_i, mode_i, rise_cnt);
    end
  endtask

  // microphone models: left drives after rise, right after fall
  always @(posedge pdm_clk_o) begin
    rise_cnt++;
    if (mode_i != 2'd2) begin
      #2 pdm_dat_i = lbit(rise_cnt);
    end
  end
  always @(negedge pdm_clk_o) begin
    if (mode_i != 2'd1 && en_i) begin
      #2 pdm_dat_i = rbit(rise_cnt);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic rose, pulse, use_l, use_r;
      rose  = pdm_clk_o && !prev_clk;
      pulse = rose && (rise_cnt > WAKE);
      use_l = (mode_i != 2'd2);
      use_r = (mode_i != 2'd1);
      check("R5/R6/R7 left strobe", left_vld_o, pulse && use_l);
      check("R5/R6/R7 right strobe", right_vld_o, pulse && use_r);
      if (pulse && use_l) check("R3 left bit", left_o, lbit(rise_cnt - 1));
      if (pulse && use_r) check("R4 right bit", right_o, rbit(rise_cnt - 1));
      if (meas_on) begin
        if (pdm_clk_o == prev_clk) run_len++;
        else begin
          if (seen_edge) begin
            n_chk++;
            if (run_len != exp_half) begin
              n_err++;
              $display("FAIL R2 phase length: actual %0d expected %0d", run_len, exp_half);
            end
          end
          seen_edge = 1'b1;
          run_len = 1;
        end
      end
      prev_clk = pdm_clk_o;
    end
  end

  task automatic run_case(int h, int m, int nrise);
    @(negedge clk_i);
    half_div_i = DIV_W'(h);
    mode_i     = 2'(m);
    exp_half   = (h == 0) ? 1 : h;
    rise_cnt   = 0;
    seen_edge  = 1'b0;
    run_len    = 0;
    meas_on    = 1'b1;
    en_i       = 1'b1;
    while (rise_cnt < nrise) @(negedge clk_i);
    repeat (2 * exp_half + 2) @(negedge clk_i);
    meas_on = 1'b0;
    en_i    = 1'b0;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      check("R1 idle clock low", pdm_clk_o, 1'b0);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset clock", pdm_clk_o, 1'b0);
    check("R1 reset left strobe", left_vld_o, 1'b0);
    check("R1 reset right strobe", right_vld_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 disabled clock", pdm_clk_o, 1'b0);
    // R8: short enable inside the start-up window, then full runs
    run_case(2, 0, 3);
    for (int h = 0; h <= 6; h++)
      for (int m = 0; m < 4; m++)
        run_case(h, m, WAKE + 6);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule